// File: doc/BRIEF.md
# Halfword Multiply-Accumulate Execute Unit

This unit performs one 16-bit by 16-bit multiply per accepted operation. A small selector chooses which halves of the two 32-bit source words are paired and whether they are signed. The 32-bit product is either the result on its own, or it is added to or subtracted from a 32-bit accumulator word. Accumulating operations can detect signed or unsigned overflow, clamp the result to a saturation value, and record the event in a pair of overflow flags. The sticky summary flag collects every recorded overflow.

Operations arrive on a valid/ready handshake. The result, the flags and an optional four-bit condition field appear at the registered outputs one cycle after acceptance. They stay there until the consumer takes them. The condition field classifies the final result against zero as a signed value and carries a copy of the summary flag.

Top module: `halfword_mac`

## Requirements
- R1: `pairSel[2]` picks the low (1) or high (0) half of `srcA`, `pairSel[3]` does the same for `srcB`, and `pairSel[0]` marks signed (1) or unsigned (0) operation. The codes 0x5/0x4 pair A-low with B-high, 0x1/0x0 pair the two high halves, and 0xD/0xC pair the two low halves.
- R2: Signed modes sign-extend each chosen half and unsigned modes zero-extend it. With `accEn` low, the result is the low 32 bits of the product, `accT` is ignored, and both flags keep their values.
- R3: With `accEn` high, the result is `accT` plus the product, or `accT` minus the product when `negEn` is also high, taken modulo 2^32.
- R4: In signed accumulating modes, overflow exists when `accT` and the addend share a sign and the 32-bit sum's sign differs from `accT`. For subtraction the addend is the two's-complement negation of the product.
- R5: In unsigned accumulating modes, overflow exists when the 33-bit sum of `accT` and the addend has a carry out of bit 31.
- R6: With `satEn` high and a signed overflow, the result is 0x7FFFFFFF when `accT` is non-negative and 0x80000000 when it is negative.
- R7: With `satEn` high and an unsigned overflow, the result is 0xFFFFFFFF. Saturation does not depend on `ovRecord`.
- R8: For an accepted accumulating operation with `ovRecord` high, `ovFlag` becomes 1 and `soFlag` becomes 1 on overflow, and `ovFlag` becomes 0 otherwise. For any other operation, `ovFlag` is unchanged.
- R9: Reset clears `ovFlag`, `soFlag` and `outValid`. Outside reset, `soFlag` never returns to 0.
- R10: An accepted operation with `recEn` high loads `condField` with {LT, GT, EQ, SO} in bits 3 down to 0, taken from the final (possibly saturated) result compared with zero as a signed value and from the updated `soFlag`. Without `recEn`, `condField` holds its value.
- R11: `inReady` is high when `outValid` is low or `outReady` is high. The result is registered at the edge that accepts the operation. While `outValid` is high and `outReady` is low, the outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation offered |
| inReady | output | 1 | Operation can be accepted |
| srcA | input | 32 | First source word |
| srcB | input | 32 | Second source word |
| accT | input | 32 | Accumulator word |
| pairSel | input | 4 | Half pairing and signedness code |
| accEn | input | 1 | Accumulate the product into `accT` |
| negEn | input | 1 | Subtract instead of add when accumulating |
| ovRecord | input | 1 | Record overflow in the flags |
| satEn | input | 1 | Clamp the result on overflow |
| recEn | input | 1 | Load the condition field |
| outValid | output | 1 | Result available |
| outReady | input | 1 | Consumer takes the result |
| result | output | 32 | Final result |
| ovFlag | output | 1 | Overflow flag |
| soFlag | output | 1 | Sticky summary overflow flag |
| condField | output | 4 | {LT, GT, EQ, SO} |

## Verification
The hardest situation to reach is a subtracting accumulation that overflows in the signed sense. It needs the most negative halfword multiplied by a positive one, so the negated product is positive, and an accumulator near the positive limit. Checking signs against the raw product instead of its negation would miss that case. The stimulus table builds it directly. It also orders overflow-recording and non-recording operations so that the flag state at each step tells "unchanged" apart from "cleared". A backpressure sequence then offers a second operation while the output is stalled, and checks that neither the result nor the condition field moves.

// File: rtl/halfword_mac_pkg.sv
package halfword_mac_pkg;

  // Bit positions inside the condition field
  localparam int COND_LT = 3;
  localparam int COND_GT = 2;
  localparam int COND_EQ = 1;
  localparam int COND_SO = 0;
  localparam int COND_W  = 4;

  // Bit positions inside the pairing selector
  localparam int SEL_SIGNED = 0;
  localparam int SEL_A_LOW  = 2;
  localparam int SEL_B_LOW  = 3;
  localparam int SEL_W      = 4;

  typedef struct packed {
    logic [SEL_W-1:0] pairSel;
    logic             accEn;
    logic             negEn;
    logic             ovRecord;
    logic             satEn;
    logic             recEn;
  } macCmd_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic loadCond;
  } dpStrobe_t;

endpackage

// File: rtl/halfword_mac_opsel.sv
module halfword_mac_opsel #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] word,
  input  logic              pickLow,
  input  logic              signedMode,
  output logic [DATA_W-1:0] extOp
);
  localparam int HALF_W = DATA_W / 2;

  logic [HALF_W-1:0] half;
  logic              fillBit;

  always_comb begin
    half    = pickLow ? word[HALF_W-1:0] : word[DATA_W-1:HALF_W];
    fillBit = signedMode & half[HALF_W-1];
    extOp   = {{(DATA_W-HALF_W){fillBit}}, half};
  end
endmodule

// File: rtl/halfword_mac_datapath.sv
module halfword_mac_datapath
  import halfword_mac_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] accT,
  input  macCmd_t           cmd,
  input  dpStrobe_t         strobe,
  input  logic              soNext,
  output logic              ovfDet,
  output logic [DATA_W-1:0] result,
  output logic [COND_W-1:0] condField
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] srcWord [2];
  logic [DATA_W-1:0] extOp   [2];
  logic [DATA_W-1:0] product;
  logic [DATA_W-1:0] addend;
  logic [DATA_W:0]   sumWide;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] clampVal;
  logic [DATA_W-1:0] finalRes;
  logic [COND_W-1:0] condNext;
  logic              isSigned;
  logic              signedOvf;
  logic              unsignedOvf;
  logic [DATA_W-1:0] resultQ;
  logic [COND_W-1:0] condQ;

  assign srcWord[0] = srcA;
  assign srcWord[1] = srcB;
  assign isSigned   = cmd.pairSel[SEL_SIGNED];

  // One half selector per source word
  for (genvar gi = 0; gi < 2; gi++) begin : g_opsel
    halfword_mac_opsel #(.DATA_W(DATA_W)) u_opsel (
      .word      (srcWord[gi]),
      .pickLow   (cmd.pairSel[SEL_A_LOW + gi]),
      .signedMode(isSigned),
      .extOp     (extOp[gi])
    );
  end

  always_comb begin
    product     = extOp[0] * extOp[1];
    addend      = cmd.negEn ? -product : product;
    sumWide     = {1'b0, accT} + {1'b0, addend};
    sum         = sumWide[DATA_W-1:0];
    signedOvf   = (accT[MSB] == addend[MSB]) && (sum[MSB] != accT[MSB]);
    unsignedOvf = sumWide[DATA_W];
    ovfDet      = cmd.accEn && (isSigned ? signedOvf : unsignedOvf);
    clampVal    = isSigned ? {accT[MSB], {(DATA_W-1){~accT[MSB]}}}
                           : {DATA_W{1'b1}};
    if (!cmd.accEn)
      finalRes = product;
    else if (cmd.satEn && ovfDet)
      finalRes = clampVal;
    else
      finalRes = sum;
    condNext[COND_LT] = finalRes[MSB];
    condNext[COND_GT] = ~finalRes[MSB] & (|finalRes);
    condNext[COND_EQ] = ~(|finalRes);
    condNext[COND_SO] = soNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
      condQ   <= '0;
    end else begin
      if (strobe.capture)  resultQ <= finalRes;
      if (strobe.loadCond) condQ   <= condNext;
    end
  end

  assign result    = resultQ;
  assign condField = condQ;
endmodule

// File: rtl/halfword_mac_ctrl.sv
module halfword_mac_ctrl
  import halfword_mac_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      outReady,
  input  macCmd_t   cmd,
  input  logic      ovfDet,
  output logic      inReady,
  output logic      outValid,
  output logic      ovFlag,
  output logic      soFlag,
  output logic      soNext,
  output dpStrobe_t strobe
);
  logic validQ;
  logic ovQ;
  logic soQ;
  logic accept;
  logic updFlags;
  logic ovNext;

  always_comb begin
    inReady         = !validQ || outReady;
    accept          = inValid && inReady;
    updFlags        = accept && cmd.accEn && cmd.ovRecord;
    ovNext          = updFlags ? ovfDet : ovQ;
    soNext          = soQ | (updFlags & ovfDet);
    strobe.capture  = accept;
    strobe.loadCond = accept && cmd.recEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0;
      ovQ    <= 1'b0;
      soQ    <= 1'b0;
    end else begin
      if (accept)        validQ <= 1'b1;
      else if (outReady) validQ <= 1'b0;
      ovQ <= ovNext;
      soQ <= soNext;
    end
  end

  assign outValid = validQ;
  assign ovFlag   = ovQ;
  assign soFlag   = soQ;
endmodule

// File: rtl/halfword_mac.sv
module halfword_mac
  import halfword_mac_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] accT,
  input  logic [3:0]        pairSel,
  input  logic              accEn,
  input  logic              negEn,
  input  logic              ovRecord,
  input  logic              satEn,
  input  logic              recEn,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] result,
  output logic              ovFlag,
  output logic              soFlag,
  output logic [3:0]        condField
);
  macCmd_t   cmd;
  dpStrobe_t strobe;
  logic      ovfDet;
  logic      soNext;

  assign cmd = '{pairSel: pairSel, accEn: accEn, negEn: negEn,
                 ovRecord: ovRecord, satEn: satEn, recEn: recEn};

  halfword_mac_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .outReady(outReady),
    .cmd     (cmd),
    .ovfDet  (ovfDet),
    .inReady (inReady),
    .outValid(outValid),
    .ovFlag  (ovFlag),
    .soFlag  (soFlag),
    .soNext  (soNext),
    .strobe  (strobe)
  );

  halfword_mac_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .srcA     (srcA),
    .srcB     (srcB),
    .accT     (accT),
    .cmd      (cmd),
    .strobe   (strobe),
    .soNext   (soNext),
    .ovfDet   (ovfDet),
    .result   (result),
    .condField(condField)
  );
endmodule

// File: rtl/halfword_mac_chk.sv
module halfword_mac_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              accEn,
  input logic              ovRecord,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] result,
  input logic              ovFlag,
  input logic              soFlag,
  input logic [3:0]        condField
);
  // R9: the summary flag is sticky outside reset
  p_so_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    soFlag |=> soFlag);

  // R8: a set overflow flag always comes with the summary flag
  p_ov_has_so_r8: assert property (@(posedge clk) disable iff (!rstN)
    ovFlag |-> soFlag);

  // R8: flags move only on an accepted, recording accumulation
  p_flags_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && inReady && accEn && ovRecord) |=> $stable(ovFlag) && $stable(soFlag));

  // R11: acceptance produces a valid output on the next cycle
  p_accept_r11: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);

  // R11: a stalled output holds
  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid && $stable(result) && $stable(condField));
endmodule

bind halfword_mac halfword_mac_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .accEn    (accEn),
  .ovRecord (ovRecord),
  .outValid (outValid),
  .outReady (outReady),
  .result   (result),
  .ovFlag   (ovFlag),
  .soFlag   (soFlag),
  .condField(condField)
);

// File: tb/halfword_mac_tb.sv
module halfword_mac_tb;
  localparam int VW = 138;
  localparam int NV = 19;

  // {pairSel, accEn negEn ovRecord satEn recEn, A, B, T, expected result, overflow exists}
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'h5, 5'b00000, 32'h1234FFFE, 32'h00035555, 32'hDEADBEEF, 32'hFFFFFFFA, 1'b0}, // R1 R2 signed cross
    {4'h4, 5'b00000, 32'h1234FFFE, 32'h00035555, 32'h00000000, 32'h0002FFFA, 1'b0}, // R1 unsigned cross
    {4'h1, 5'b00000, 32'h80000000, 32'h80001111, 32'h00000000, 32'h40000000, 1'b0}, // R1 signed high-high
    {4'h0, 5'b00000, 32'hFFFF0000, 32'hFFFF0000, 32'h00000000, 32'hFFFE0001, 1'b0}, // R1 unsigned high-high
    {4'hD, 5'b00000, 32'h00007FFF, 32'h7777FFFF, 32'h00000000, 32'hFFFF8001, 1'b0}, // R1 signed low-low
    {4'hC, 5'b00000, 32'hAAAA0010, 32'hBBBB0020, 32'h00000000, 32'h00000200, 1'b0}, // R1 unsigned low-low
    {4'hD, 5'b10101, 32'h00000002, 32'h00000003, 32'h00000010, 32'h00000016, 1'b0}, // R3 add
    {4'h1, 5'b10111, 32'h7FFF0000, 32'h7FFF0000, 32'h70000000, 32'h7FFFFFFF, 1'b1}, // R6 positive clamp
    {4'hD, 5'b10111, 32'h0000FFFF, 32'h00000005, 32'h00000003, 32'hFFFFFFFE, 1'b0}, // R4 mixed signs
    {4'h1, 5'b10001, 32'h7FFF0000, 32'h7FFF0000, 32'h70000000, 32'hAFFF0001, 1'b1}, // R8 not recorded
    {4'h1, 5'b10101, 32'h7FFF0000, 32'h7FFF0000, 32'h70000000, 32'hAFFF0001, 1'b1}, // R4 wrap, recorded
    {4'hC, 5'b00101, 32'h0000FFFF, 32'h0000FFFF, 32'h00000000, 32'hFFFE0001, 1'b0}, // R2 flags kept
    {4'hD, 5'b10111, 32'h00008000, 32'h00007FFF, 32'h80000000, 32'h80000000, 1'b1}, // R6 negative clamp
    {4'hC, 5'b10010, 32'h0000FFFF, 32'h0000FFFF, 32'h00020000, 32'hFFFFFFFF, 1'b1}, // R7 clamp, no record
    {4'hC, 5'b10111, 32'h00000002, 32'h00000003, 32'h00000010, 32'h00000016, 1'b0}, // R5 no carry
    {4'hD, 5'b11100, 32'h00000002, 32'h00000003, 32'h00000010, 32'h0000000A, 1'b0}, // R3 subtract
    {4'hD, 5'b11111, 32'h00008000, 32'h00000001, 32'h7FFFFFF0, 32'h7FFFFFFF, 1'b1}, // R4 negated addend
    {4'hD, 5'b11001, 32'h00000001, 32'h00000010, 32'h00000010, 32'h00000000, 1'b0}, // R10 EQ
    {4'hC, 5'b11100, 32'h00000001, 32'h00000010, 32'h00000020, 32'h00000010, 1'b1}  // R5 subtract carry
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] srcA = '0;
  logic [31:0] srcB = '0;
  logic [31:0] accT = '0;
  logic [3:0]  pairSel = '0;
  logic        accEn = 1'b0;
  logic        negEn = 1'b0;
  logic        ovRecord = 1'b0;
  logic        satEn = 1'b0;
  logic        recEn = 1'b0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [31:0] result;
  logic        ovFlag;
  logic        soFlag;
  logic [3:0]  condField;

  int checks = 0;
  int errors = 0;
  logic       mOv = 1'b0;
  logic       mSo = 1'b0;
  logic [3:0] mCond = '0;

  always #10 clk = ~clk;

  halfword_mac u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .srcA(srcA), .srcB(srcB), .accT(accT), .pairSel(pairSel),
    .accEn(accEn), .negEn(negEn), .ovRecord(ovRecord), .satEn(satEn),
    .recEn(recEn), .outValid(outValid), .outReady(outReady),
    .result(result), .ovFlag(ovFlag), .soFlag(soFlag), .condField(condField)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] condOf(input logic [31:0] r, input logic so);
    return {r[31], ~r[31] & (r != 0), r == 0, so};
  endfunction

  task automatic drive(input logic [3:0] sel, input logic [4:0] fl,
                       input logic [31:0] a, input logic [31:0] b, input logic [31:0] t);
    pairSel = sel;
    {accEn, negEn, ovRecord, satEn, recEn} = fl;
    srcA = a; srcB = b; accT = t;
  endtask

  // Drive at a falling edge, accept at the rising edge, sample at the next falling edge
  task automatic issue(input logic [3:0] sel, input logic [4:0] fl,
                       input logic [31:0] a, input logic [31:0] b, input logic [31:0] t);
    @(negedge clk);
    drive(sel, fl, a, b, t);
    inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 outValid at reset", {31'b0, outValid}, 32'd0);
    check("R9 flags at reset", {30'b0, ovFlag, soFlag}, 32'd0);
    check("R11 inReady at reset", {31'b0, inReady}, 32'd1);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      logic [4:0]    fl;
      logic [31:0]   expRes;
      logic          ovf;
      string         tag;
      v      = VEC[i];
      fl     = v[133:129];
      expRes = v[32:1];
      ovf    = v[0];
      issue(v[137:134], fl, v[128:97], v[96:65], v[64:33]);
      if (fl[4] && fl[2]) begin
        mOv = ovf;
        mSo = mSo | ovf;
      end
      if (fl[0]) mCond = condOf(expRes, mSo);
      tag = !fl[4] ? "R1 R2 product" : (fl[1] ? "R6 R7 result" : "R3 R4 R5 result");
      check($sformatf("%s row %0d", tag, i), result, expRes);
      check($sformatf("R11 outValid row %0d", i), {31'b0, outValid}, 32'd1);
      check($sformatf("R8 ovFlag row %0d", i), {31'b0, ovFlag}, {31'b0, mOv});
      check($sformatf("R9 soFlag row %0d", i), {31'b0, soFlag}, {31'b0, mSo});
      check($sformatf("R10 condField row %0d", i), {28'b0, condField}, {28'b0, mCond});
    end

    // R10: an operation without the record bit leaves the condition field alone
    issue(4'hC, 5'b00000, 32'h00000003, 32'h00000003, 32'h0);
    check("R2 product 9", result, 32'h00000009);
    check("R10 condField held", {28'b0, condField}, {28'b0, mCond});

    // R11: backpressure holds result and blocks new input
    issue(4'hC, 5'b00001, 32'h00000004, 32'h00000005, 32'h0);
    check("R11 first result", result, 32'h00000014);
    outReady = 1'b0;
    drive(4'hC, 5'b00001, 32'h00000006, 32'h00000007, 32'h0);
    inValid = 1'b1;
    @(negedge clk);
    check("R11 inReady low while stalled", {31'b0, inReady}, 32'd0);
    @(negedge clk);
    check("R11 result held", result, 32'h00000014);
    check("R11 cond held", {28'b0, condField}, {28'b0, condOf(32'h14, mSo)});
    check("R11 outValid held", {31'b0, outValid}, 32'd1);
    outReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    check("R11 second result after release", result, 32'h0000002A);
    @(negedge clk);
    check("R11 outValid drops", {31'b0, outValid}, 32'd0);

    // R9: reset clears sticky flag
    check("R9 soFlag set before reset", {31'b0, soFlag}, 32'd1);
    rstN = 1'b0;
    @(negedge clk);
    check("R9 flags cleared by reset", {30'b0, ovFlag, soFlag}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule